// File: doc/BRIEF.md
# Raster-Position and Vertical-Blank Interrupt Controller

This block raises interrupt requests for a graphics processor from two timing sources. The first is the vertical blanking point of the frame. The second is a raster line that software picks. Each source has a 3-bit priority code, and that code chooses which of eight CPU request lines the source drives. A requested line stays high until software touches that source's acknowledge window, or until it rewrites either priority code. Rewriting a priority code drops every pending line at once.

The host reaches the block over a 16-bit register bus. The bus carries a word address, separate read and write strobes, and byte-lane enables. The raster compare value is written and read through its own chip-select, with the data on the low byte. The video timing side supplies a scan counter that runs at twice the line rate, together with a strobe that marks the start of each count. Both sources are evaluated only on that strobe, so each matching count raises its line once per frame.

Top module: `scan_irq_ctrl`

## Requirements
- R1: After reset, all eight request lines are low, both priority codes read back as 0, and the raster compare value reads back as 0.
- R2: A write with byte lane 0 enabled loads a priority code from data bits [2:0]. A read returns the code in bits [2:0] with bits [15:3] zero. A write with byte lane 0 disabled leaves the code unchanged.
- R3: The window is selected by word address bits [15:12]. The codes are 0x5 for the raster priority, 0x7 for the blanking priority, 0xD for the raster acknowledge and 0xF for the blanking acknowledge. Accesses to any other code change nothing and read 0.
- R4: On a line-start strobe with a scan count of 480, the line indexed by the blanking priority is set.
- R5: On a line-start strobe with a scan count equal to twice the compare value, the line indexed by the raster priority is set. A count of twice the compare value plus one sets nothing.
- R6: When the compare select is high, a write with byte lane 0 loads the compare value from bits [7:0], and a read returns it in bits [7:0] with the upper bits zero. The main address decode is ignored during such an access.
- R7: A read or a write to an acknowledge window, with any byte lanes, clears the line selected by that source's current priority code. The read returns 0.
- R8: Any write to either priority window clears all eight request lines.
- R9: A set line holds until it is acknowledged or cleared by R8. No line rises unless the line-start strobe was high in the previous cycle.
- R10: If a source raises a line in the same cycle that an acknowledge clears it, the line ends up set.
- R11: If both sources share one priority code, a single acknowledge clears the shared line.
- R12: Register and line updates appear at the clock edge that samples the strobe. Read data is combinational in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 16 | Word address of the host access |
| busRd | input | 1 | Read strobe |
| busWr | input | 1 | Write strobe |
| busByteEn | input | 2 | Byte-lane enables, bit 0 = low byte |
| busWrData | input | 16 | Write data |
| busRdData | output | 16 | Read data, combinational |
| cmpSel | input | 1 | Selects the raster compare port instead of the main window |
| scanCount | input | 10 | Scan count at twice the line rate |
| lineStart | input | 1 | Marks a new scan count |
| irqLines | output | 8 | CPU interrupt request lines, indexed by priority code |

## Verification
The bound checker checks the following on every cycle:
- that each source's line comes up one edge after its match;
- that a priority write with no concurrent strobe leaves every line low;
- that acknowledge reads return zero and priority reads keep their upper bits clear;
- that no line rises without a preceding line-start strobe.

Other behaviour only the bench's scenarios can show. This covers window decoding of unrelated addresses, byte-lane gating, the compare port overriding the main decode, trigger-over-acknowledge precedence, shared-level acknowledge, and the sweep of all eight codes and all 256 compare values.

// File: rtl/scan_irq_pkg.sv
package scan_irq_pkg;

  // One-cycle commands from the decoder to the register datapath
  typedef struct packed {
    logic wrPosLvl;
    logic wrVblLvl;
    logic wrCmp;
    logic ackPos;
    logic ackVbl;
    logic lineEvt;
  } ctlStrobes_t;

  typedef enum logic [1:0] {
    RD_NONE   = 2'd0,
    RD_POSLVL = 2'd1,
    RD_VBLLVL = 2'd2,
    RD_CMP    = 2'd3
  } rdSel_t;

endpackage

// File: rtl/scan_irq_ctl.sv
module scan_irq_ctl
  import scan_irq_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int WIN_LSB     = 12,
  parameter int POS_LVL_WIN = 5,
  parameter int VBL_LVL_WIN = 7,
  parameter int POS_ACK_WIN = 13,
  parameter int VBL_ACK_WIN = 15
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [1:0]        busByteEn,
  input  logic              cmpSel,
  input  logic              lineStart,
  output ctlStrobes_t       strobes,
  output rdSel_t            rdSel
);

  localparam int WIN_W = ADDR_W - WIN_LSB;

  logic [WIN_W-1:0] winCode;
  logic             access;
  logic             mainAccess;
  logic             lowLane;
  logic             hitPosLvl, hitVblLvl, hitPosAck, hitVblAck;
  logic             unusedCtl;

  assign winCode    = busAddr[ADDR_W-1:WIN_LSB];
  assign access     = busRd | busWr;
  assign mainAccess = access & ~cmpSel;
  assign lowLane    = busByteEn[0];
  assign unusedCtl  = ^{busAddr[WIN_LSB-1:0], busByteEn[1]};

  assign hitPosLvl = (winCode == WIN_W'(POS_LVL_WIN));
  assign hitVblLvl = (winCode == WIN_W'(VBL_LVL_WIN));
  assign hitPosAck = (winCode == WIN_W'(POS_ACK_WIN));
  assign hitVblAck = (winCode == WIN_W'(VBL_ACK_WIN));

  always_comb begin
    strobes          = '0;
    strobes.wrPosLvl = busWr & ~cmpSel & lowLane & hitPosLvl;
    strobes.wrVblLvl = busWr & ~cmpSel & lowLane & hitVblLvl;
    strobes.wrCmp    = busWr & cmpSel & lowLane;
    strobes.ackPos   = mainAccess & hitPosAck;
    strobes.ackVbl   = mainAccess & hitVblAck;
    strobes.lineEvt  = lineStart;
  end

  always_comb begin
    rdSel = RD_NONE;
    if (busRd) begin
      if (cmpSel)         rdSel = RD_CMP;
      else if (hitPosLvl) rdSel = RD_POSLVL;
      else if (hitVblLvl) rdSel = RD_VBLLVL;
    end
  end

endmodule

// File: rtl/scan_irq_dp.sv
module scan_irq_dp
  import scan_irq_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int LVL_W     = 3,
  parameter int CMP_W     = 8,
  parameter int SCAN_W    = 10,
  parameter int VBL_COUNT = 480
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctlStrobes_t              strobes,
  input  rdSel_t                   rdSel,
  input  logic [DATA_W-1:0]        wrData,
  input  logic [SCAN_W-1:0]        scanCount,
  output logic [DATA_W-1:0]        rdData,
  output logic [(1<<LVL_W)-1:0]    irqLines,
  output logic [LVL_W-1:0]         posLvl,
  output logic [LVL_W-1:0]         vblLvl,
  output logic [CMP_W-1:0]         cmpVal
);

  localparam int NUM_LINES = 1 << LVL_W;

  logic trigVbl, trigPos, flushAll;
  logic [NUM_LINES-1:0] linesNext;
  logic unusedDp;

  assign unusedDp = ^wrData[DATA_W-1:CMP_W];

  // Source triggers, sampled only on a line-start strobe
  assign trigVbl  = strobes.lineEvt & (scanCount == SCAN_W'(VBL_COUNT));
  assign trigPos  = strobes.lineEvt & (scanCount == SCAN_W'({cmpVal, 1'b0}));
  assign flushAll = strobes.wrPosLvl | strobes.wrVblLvl;

  // Per-line next state: trigger beats acknowledge and flush
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    logic setHit, clrHit;
    assign setHit = (trigPos & (posLvl == LVL_W'(i))) |
                    (trigVbl & (vblLvl == LVL_W'(i)));
    assign clrHit = flushAll |
                    (strobes.ackPos & (posLvl == LVL_W'(i))) |
                    (strobes.ackVbl & (vblLvl == LVL_W'(i)));
    assign linesNext[i] = setHit | (irqLines[i] & ~clrHit);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqLines <= '0;
      posLvl   <= '0;
      vblLvl   <= '0;
      cmpVal   <= '0;
    end else begin
      irqLines <= linesNext;
      if (strobes.wrPosLvl) posLvl <= wrData[LVL_W-1:0];
      if (strobes.wrVblLvl) vblLvl <= wrData[LVL_W-1:0];
      if (strobes.wrCmp)    cmpVal <= wrData[CMP_W-1:0];
    end
  end

  always_comb begin
    unique case (rdSel)
      RD_POSLVL: rdData = DATA_W'(posLvl);
      RD_VBLLVL: rdData = DATA_W'(vblLvl);
      RD_CMP:    rdData = DATA_W'(cmpVal);
      default:   rdData = '0;
    endcase
  end

endmodule

// File: rtl/scan_irq_ctrl.sv
module scan_irq_ctrl
  import scan_irq_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 16,
  parameter int LVL_W       = 3,
  parameter int CMP_W       = 8,
  parameter int SCAN_W      = 10,
  parameter int VBL_COUNT   = 480,
  parameter int WIN_LSB     = 12,
  parameter int POS_LVL_WIN = 5,
  parameter int VBL_LVL_WIN = 7,
  parameter int POS_ACK_WIN = 13,
  parameter int VBL_ACK_WIN = 15
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic                  busRd,
  input  logic                  busWr,
  input  logic [1:0]            busByteEn,
  input  logic [DATA_W-1:0]     busWrData,
  output logic [DATA_W-1:0]     busRdData,
  input  logic                  cmpSel,
  input  logic [SCAN_W-1:0]     scanCount,
  input  logic                  lineStart,
  output logic [(1<<LVL_W)-1:0] irqLines
);

  ctlStrobes_t       strobes;
  rdSel_t            rdSel;
  logic [LVL_W-1:0]  posLvl;
  logic [LVL_W-1:0]  vblLvl;
  logic [CMP_W-1:0]  cmpVal;

  scan_irq_ctl #(
    .ADDR_W(ADDR_W), .WIN_LSB(WIN_LSB),
    .POS_LVL_WIN(POS_LVL_WIN), .VBL_LVL_WIN(VBL_LVL_WIN),
    .POS_ACK_WIN(POS_ACK_WIN), .VBL_ACK_WIN(VBL_ACK_WIN)
  ) ctl_i (
    .busAddr(busAddr), .busRd(busRd), .busWr(busWr), .busByteEn(busByteEn),
    .cmpSel(cmpSel), .lineStart(lineStart), .strobes(strobes), .rdSel(rdSel)
  );

  scan_irq_dp #(
    .DATA_W(DATA_W), .LVL_W(LVL_W), .CMP_W(CMP_W),
    .SCAN_W(SCAN_W), .VBL_COUNT(VBL_COUNT)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .rdSel(rdSel),
    .wrData(busWrData), .scanCount(scanCount), .rdData(busRdData),
    .irqLines(irqLines), .posLvl(posLvl), .vblLvl(vblLvl), .cmpVal(cmpVal)
  );

endmodule

// File: rtl/scan_irq_chk.sv
module scan_irq_chk #(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 16,
  parameter int LVL_W       = 3,
  parameter int CMP_W       = 8,
  parameter int SCAN_W      = 10,
  parameter int VBL_COUNT   = 480,
  parameter int WIN_LSB     = 12,
  parameter int POS_LVL_WIN = 5,
  parameter int VBL_LVL_WIN = 7,
  parameter int POS_ACK_WIN = 13,
  parameter int VBL_ACK_WIN = 15
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [ADDR_W-1:0]     busAddr,
  input logic                  busRd,
  input logic                  busWr,
  input logic [1:0]            busByteEn,
  input logic                  cmpSel,
  input logic [DATA_W-1:0]     busRdData,
  input logic [SCAN_W-1:0]     scanCount,
  input logic                  lineStart,
  input logic [(1<<LVL_W)-1:0] irqLines,
  input logic [LVL_W-1:0]      posLvl,
  input logic [LVL_W-1:0]      vblLvl,
  input logic [CMP_W-1:0]      cmpVal
);

  localparam int WIN_W = ADDR_W - WIN_LSB;
  logic [WIN_W-1:0] win;
  assign win = busAddr[ADDR_W-1:WIN_LSB];

  p_vbl_raise_r4: assert property (@(posedge clk) disable iff (!rstN)
    (lineStart && scanCount == SCAN_W'(VBL_COUNT)) |=> irqLines[$past(vblLvl)]);

  p_pos_raise_r5: assert property (@(posedge clk) disable iff (!rstN)
    (lineStart && scanCount == SCAN_W'({cmpVal, 1'b0})) |=> irqLines[$past(posLvl)]);

  p_ack_read_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && !cmpSel && (win == WIN_W'(POS_ACK_WIN) || win == WIN_W'(VBL_ACK_WIN)))
      |-> (busRdData == '0));

  p_lvl_read_width_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && !cmpSel && (win == WIN_W'(POS_LVL_WIN) || win == WIN_W'(VBL_LVL_WIN)))
      |-> (busRdData[DATA_W-1:LVL_W] == '0));

  p_flush_all_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && !cmpSel && busByteEn[0] && !lineStart &&
     (win == WIN_W'(POS_LVL_WIN) || win == WIN_W'(VBL_LVL_WIN)))
      |=> (irqLines == '0));

  p_no_spont_rise_r9: assert property (@(posedge clk) disable iff (!rstN)
    (|(irqLines & ~$past(irqLines))) |-> $past(lineStart));

endmodule

bind scan_irq_ctrl scan_irq_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LVL_W(LVL_W), .CMP_W(CMP_W),
  .SCAN_W(SCAN_W), .VBL_COUNT(VBL_COUNT), .WIN_LSB(WIN_LSB),
  .POS_LVL_WIN(POS_LVL_WIN), .VBL_LVL_WIN(VBL_LVL_WIN),
  .POS_ACK_WIN(POS_ACK_WIN), .VBL_ACK_WIN(VBL_ACK_WIN)
) chk_i (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
  .busByteEn(busByteEn), .cmpSel(cmpSel), .busRdData(busRdData),
  .scanCount(scanCount), .lineStart(lineStart), .irqLines(irqLines),
  .posLvl(posLvl), .vblLvl(vblLvl), .cmpVal(cmpVal)
);

// File: tb/scan_irq_ctrl_tb.sv
module scan_irq_ctrl_tb_top;

  localparam logic [15:0] A_POSLVL = 16'h5000;
  localparam logic [15:0] A_VBLLVL = 16'h7000;
  localparam logic [15:0] A_POSACK = 16'hD000;
  localparam logic [15:0] A_VBLACK = 16'hF000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] busAddr = '0;
  logic        busRd = 1'b0, busWr = 1'b0, cmpSel = 1'b0, lineStart = 1'b0;
  logic [1:0]  busByteEn = '0;
  logic [15:0] busWrData = '0;
  logic [15:0] busRdData;
  logic [9:0]  scanCount = '0;
  logic [7:0]  irqLines;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [7:0] expLines = '0;
  logic [2:0] expPos = '0, expVbl = '0;
  logic [7:0] expCmp = '0;
  logic [15:0] rv;

  always #4 clk = ~clk;

  scan_irq_ctrl dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
    .busByteEn(busByteEn), .busWrData(busWrData), .busRdData(busRdData),
    .cmpSel(cmpSel), .scanCount(scanCount), .lineStart(lineStart),
    .irqLines(irqLines)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One bus/timing cycle driven at negedge; read data sampled before the edge
  task automatic op(input logic [15:0] a, input logic rd, input logic wr,
                    input logic [1:0] be, input logic [15:0] d, input logic sel,
                    input logic [9:0] sc, input logic ls, output logic [15:0] rdv);
    @(negedge clk);
    busAddr = a; busRd = rd; busWr = wr; busByteEn = be; busWrData = d;
    cmpSel = sel; scanCount = sc; lineStart = ls;
    #1 rdv = busRdData;
    @(negedge clk);
    busRd = 1'b0; busWr = 1'b0; cmpSel = 1'b0; lineStart = 1'b0; busByteEn = '0;
  endtask

  task automatic wrLvl(input bit isPos, input logic [2:0] v);
    logic [15:0] t;
    op(isPos ? A_POSLVL : A_VBLLVL, 1'b0, 1'b1, 2'b11, {13'h1FFF, v}, 1'b0, 10'd0, 1'b0, t);
    if (isPos) expPos = v; else expVbl = v;
    expLines = '0;
  endtask

  task automatic wrCmp(input logic [7:0] v);
    logic [15:0] t;
    op(A_POSLVL, 1'b0, 1'b1, 2'b01, {8'hA5, v}, 1'b1, 10'd0, 1'b0, t);
    expCmp = v;
  endtask

  task automatic pulse(input logic [9:0] sc);
    logic [15:0] t;
    op(16'h0000, 1'b0, 1'b0, 2'b00, 16'h0, 1'b0, sc, 1'b1, t);
    if (sc == 10'd480) expLines[expVbl] = 1'b1;
    if (sc == {1'b0, expCmp, 1'b0}) expLines[expPos] = 1'b1;
  endtask

  task automatic ack(input bit isPos, input bit useRead, input string req);
    logic [15:0] t;
    op((isPos ? A_POSACK : A_VBLACK) | 16'h0123, useRead, !useRead, 2'b10,
       16'hFFFF, 1'b0, 10'd0, 1'b0, t);
    expLines[isPos ? expPos : expVbl] = 1'b0;
    if (useRead) check({req, " ack read data"}, t, 16'h0);
  endtask

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 lines", {8'h0, irqLines}, 16'h0);
    op(A_POSLVL, 1, 0, 2'b11, 0, 0, 0, 0, rv); check("R1 pos level", rv, 16'h0);
    op(A_VBLLVL, 1, 0, 2'b11, 0, 0, 0, 0, rv); check("R1 vbl level", rv, 16'h0);
    op(16'h0, 1, 0, 2'b11, 0, 1, 0, 0, rv);    check("R1 cmp", rv, 16'h0);

    // R2 level registers: all codes, upper bits masked, lane gating
    for (int v = 0; v < 8; v++) begin
      wrLvl(1, 3'(v));
      op(A_POSLVL | 16'h0FFF, 1, 0, 2'b00, 0, 0, 0, 0, rv);
      check("R2 pos level read", rv, 16'(v));
      wrLvl(0, 3'(7 - v));
      op(A_VBLLVL, 1, 0, 2'b00, 0, 0, 0, 0, rv);
      check("R2 vbl level read", rv, 16'(7 - v));
    end
    op(A_POSLVL, 0, 1, 2'b10, 16'h0002, 0, 0, 0, rv);
    op(A_POSLVL, 1, 0, 2'b11, 0, 0, 0, 0, rv);
    check("R2 high-lane write ignored", rv, 16'(expPos));

    // R4 blanking sweep over all codes, R7 ack by read and write, R9 near miss
    for (int l = 0; l < 8; l++) begin
      wrLvl(0, 3'(l));
      pulse(10'd479);
      check("R9 no raise at 479", {8'h0, irqLines}, {8'h0, expLines});
      pulse(10'd480);
      check("R4 vbl raise", {8'h0, irqLines}, 16'(1 << l));
      ack(1, 1, "R7");
      check("R7 pos ack leaves vbl line", {8'h0, irqLines}, {8'h0, expLines});
      ack(0, l[0], "R7");
      check("R7 vbl ack clears", {8'h0, irqLines}, 16'h0);
    end

    // R12 latency: line changes only at the edge that samples the strobe
    @(negedge clk);
    scanCount = 10'd480; lineStart = 1'b1;
    #1 check("R12 before edge", {8'h0, irqLines}, 16'h0);
    @(posedge clk); #1;
    check("R12 after edge", {8'h0, irqLines}, 16'(1 << expVbl));
    @(negedge clk); lineStart = 1'b0;
    expLines[expVbl] = 1'b1;

    // R9 hold
    repeat (10) @(negedge clk);
    check("R9 line holds", {8'h0, irqLines}, {8'h0, expLines});

    // R3 unrelated windows change nothing and read zero
    for (int w = 0; w < 16; w++) begin
      if (w != 5 && w != 7 && w != 13 && w != 15) begin
        op(16'(w << 12) | 16'h0042, 0, 1, 2'b11, 16'h0005, 0, 0, 0, rv);
        op(16'(w << 12), 1, 0, 2'b11, 0, 0, 0, 0, rv);
        check("R3 other window read", rv, 16'h0);
        check("R3 other window lines", {8'h0, irqLines}, {8'h0, expLines});
      end
    end

    // R10 trigger and ack in the same cycle: trigger wins
    op(A_VBLACK, 1, 0, 2'b11, 0, 0, 10'd480, 1, rv);
    check("R10 trigger beats ack", {8'h0, irqLines}, {8'h0, expLines});

    // R8 flush
    wrLvl(1, 3'd3);
    wrLvl(0, 3'd6);
    wrCmp(8'd10);
    pulse(10'd480);
    pulse(10'd20);
    check("R8 both raised", {8'h0, irqLines}, 16'h0048);
    wrLvl(1, 3'd3);
    check("R8 flush on level write", {8'h0, irqLines}, 16'h0);

    // R5 / R6 compare sweep over all values
    wrLvl(0, 3'd5);
    for (int c = 0; c < 256; c++) begin
      wrCmp(8'(c));
      op(16'h0, 1, 0, 2'b01, 0, 1, 0, 0, rv);
      check("R6 cmp read", rv, 16'(c));
      pulse(10'(2 * c + 1));
      check("R5 no raise at 2c+1", {8'h0, irqLines}, {8'h0, expLines});
      op(16'h0, 0, 0, 2'b00, 0, 0, 10'(2 * c), 0, rv);
      check("R9 no raise without strobe", {8'h0, irqLines}, {8'h0, expLines});
      pulse(10'(2 * c));
      check("R5 pos raise", {8'h0, irqLines}, 16'h0008 | {8'h0, expLines});
      ack(1, c[0], "R7");
      check("R7 pos ack", {8'h0, irqLines}, {8'h0, expLines});
    end

    // R6 compare port overrides main decode; lane gating
    pulse(10'd480);
    op(A_POSLVL, 0, 1, 2'b01, 16'h0007, 1, 0, 0, rv);
    expCmp = 8'h07;
    check("R6 no flush via cmp port", {8'h0, irqLines}, {8'h0, expLines});
    op(A_POSLVL, 1, 0, 2'b11, 0, 0, 0, 0, rv);
    check("R6 pos level untouched", rv, 16'(expPos));
    op(16'h0, 0, 1, 2'b10, 16'h00FF, 1, 0, 0, rv);
    op(16'h0, 1, 0, 2'b11, 0, 1, 0, 0, rv);
    check("R6 cmp high-lane ignored", rv, 16'h0007);

    // R11 shared level
    wrLvl(1, 3'd4);
    wrLvl(0, 3'd4);
    wrCmp(8'd100);
    pulse(10'd480);
    pulse(10'd200);
    check("R11 shared line", {8'h0, irqLines}, 16'h0010);
    ack(1, 0, "R11");
    check("R11 one ack clears", {8'h0, irqLines}, 16'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule